// File: doc/BRIEF.md
# Limit-Match Interval Counter Timer

This block is one counter/timer channel that a processor reaches through a 32-bit word-addressed register port. A counter advances once for each cycle in which the tick-enable input is high. In the register view the count starts at bit 9, so one tick adds 0x200 to the value read back, and bits 8..0 always read as zero. Software writes a limit. When the counter reaches that limit, it restarts from zero, sets a sticky reached flag, and raises a level interrupt. The interrupt stays high until software acknowledges it.

Word offset 0 holds the limit. A write there also restarts the count, and a read there acknowledges the event. Word offset 1 returns the count, with the reached flag in bit 31. Word offset 2 takes a new limit and leaves the running count alone. A limit of zero turns the channel into a free-running counter that never produces an event. The word offset is the byte address shifted right by two, and only full 32-bit words are transferred.

The counter width, the bit position of the count and the address width are parameters. With the default values the count field fills bits 30..9.

Top module: `lmt_timer`

## Requirements
- R1: After a synchronous active-low reset, `irq` is low and reads at word offsets 0 and 1 both return zero. In this state the limit is zero, so the counter runs free.
- R2: The count goes up by one for each clock cycle in which `tick_en` is high and does not change otherwise. A read at word offset 1 returns the count in bits FRAC_W and up (9 by default), zeros in bits 8..0, and the reached flag in bit 31.
- R3: A write at word offset 0 or 2 keeps only the count-field bits of the data as the limit. A read at word offset 0 returns that field in the same bit position and zero in every other bit, including bit 31.
- R4: A read at word offset 0 clears the reached flag and drives `irq` low on the next cycle.
- R5: A write at word offset 0 loads the limit, sets the count to zero and drives `irq` low. It leaves the reached flag unchanged.
- R6: With a nonzero limit L, the count steps through 0 to L-1. The tick taken at L-1 returns the count to 0, sets the reached flag and raises `irq`, all visible on the next cycle. This repeats every L ticks.
- R7: With a limit of zero, the count wraps from all ones to zero. The reached flag is never set and `irq` never rises.
- R8: A write at word offset 2 loads the limit and keeps the current count. If the count is already at or above the new limit, the counter runs to all ones, wraps to zero, and matches on the next pass.
- R9: Reads at word offset 2 and at offsets 3 and above return zero. Writes at word offset 1 and at offsets 3 and above change neither the count, the limit, the flag nor `irq`.
- R10: `irq` is a level. It stays high through counter reads and idle cycles until a read or a write at word offset 0 acknowledges it.
- R11: If a match and a read at word offset 0 fall in the same cycle, the clear wins and the flag and `irq` stay low. Only the following match raises them again.
- R12: If a write at word offset 0 and a tick fall in the same cycle, the count ends at zero.
- R13: `reg_rdata` is registered. It shows the addressed value on the cycle after `reg_rd` and holds that value while no read is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address; bits above 1..0 select the word |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | DATA_W | Write data |
| reg_rd | input | 1 | Read strobe for one cycle |
| reg_rdata | output | DATA_W | Registered read data |
| tick_en | input | 1 | Count enable, one increment per high cycle |
| irq | output | 1 | Interrupt level, high from a match until acknowledged |

## Verification
The hardest states to reach are those that depend on exact tick alignment. One is a match landing in the same cycle as a limit read. The other is a limit lowered below the running count, after which the counter must pass through a full wrap before it can match. The bench instantiates the block with an 8-bit counter, so a full wrap takes only a few hundred ticks. Each scenario restarts the count with a write at word offset 0 and then issues an exact number of tick cycles, which places the counter at a known value at a chosen cycle. The collision is then made by raising the tick and the limit read together on the cycle that carries the count from L-1 to zero.

// File: rtl/lmt_pkg.sv
// Shared definitions for the limit-match counter timer.
// Word offsets are fixed because software decodes them; everything else is local.
package lmt_pkg;

    // Word offsets (byte address >> 2)
    localparam int unsigned OFS_LIMIT_RESTART = 0;
    localparam int unsigned OFS_COUNT         = 1;
    localparam int unsigned OFS_LIMIT_KEEP    = 2;

    // Decoded register commands for one cycle
    typedef struct packed {
        logic load_restart;  // limit write that also zeroes the count
        logic load_keep;     // limit write that keeps the count
        logic read_limit;    // limit read, acknowledges the event
    } lmt_cmd_t;

    // Read data source
    typedef enum logic [1:0] {
        RSEL_ZERO  = 2'd0,
        RSEL_LIMIT = 2'd1,
        RSEL_COUNT = 2'd2
    } lmt_rsel_e;

endpackage

// File: rtl/lmt_addr_dec.sv
// Address decoder for the counter timer register port.
// Turns the byte address and the strobes into per-register commands and a read
// source. Assumes only whole-word accesses, so address bits 1..0 are ignored.
// Unmapped offsets produce no command and select a zero read.
module lmt_addr_dec
    import lmt_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output lmt_cmd_t          cmd,
    output lmt_rsel_e         rsel
);

    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              hit_limit_restart;
    logic              hit_count;
    logic              hit_limit_keep;
    logic              unused_byte_lane;

    assign word             = addr[ADDR_W-1:2];
    assign unused_byte_lane = ^addr[1:0];

    // Compare the word offset with each mapped register
    always_comb begin
        hit_limit_restart = (word == WORD_W'(OFS_LIMIT_RESTART));
        hit_count         = (word == WORD_W'(OFS_COUNT));
        hit_limit_keep    = (word == WORD_W'(OFS_LIMIT_KEEP));
    end

    // Produce the write and acknowledge commands for this cycle
    always_comb begin
        cmd.load_restart = wr && hit_limit_restart;
        cmd.load_keep    = wr && hit_limit_keep;
        cmd.read_limit   = rd && hit_limit_restart;
    end

    // Choose the read source; the keep-limit offset is write-only
    always_comb begin
        if (hit_limit_restart)
            rsel = RSEL_LIMIT;
        else if (hit_count)
            rsel = RSEL_COUNT;
        else
            rsel = RSEL_ZERO;
    end

endmodule

// File: rtl/lmt_count_core.sv
// Count and limit storage with the match comparator.
// Stores only the significant count bits; the constant low bits live in the
// read path. A zero limit disables matching, and the counter then wraps
// naturally at all ones. A restart beats a same-cycle tick, and a restart
// suppresses any match in that cycle.
module lmt_count_core #(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic             load_limit,
    input  logic [CNT_W-1:0] new_limit,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] limit,
    output logic             match
);

    logic [CNT_W:0] step;
    logic           limit_set;
    logic           at_limit;

    // Compute the incremented count one bit wider so that the wrap at all ones
    // never equals a limit
    always_comb begin
        step      = {1'b0, count} + {{CNT_W{1'b0}}, 1'b1};
        limit_set = |limit;
        at_limit  = limit_set && (step == {1'b0, limit});
        match     = tick && at_limit && !restart;
    end

    // Hold the limit; either limit write loads it
    always_ff @(posedge clk) begin
        if (!rst_n)
            limit <= '0;
        else if (load_limit)
            limit <= new_limit;
    end

    // Advance, restart on a match, or zero on a restarting write
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (restart)
            count <= '0;
        else if (tick)
            count <= at_limit ? '0 : step[CNT_W-1:0];
    end

endmodule

// File: rtl/lmt_event_flag.sv
// Sticky reached flag and interrupt level.
// Both are set by a match. A limit read clears both. A restarting limit write
// clears only the interrupt. A clear in the same cycle as a match wins.
module lmt_event_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic ack_read,
    input  logic ack_write,
    output logic reached,
    output logic irq
);

    // Reached flag: set on a match, cleared by a limit read
    always_ff @(posedge clk) begin
        if (!rst_n)
            reached <= 1'b0;
        else if (ack_read)
            reached <= 1'b0;
        else if (match)
            reached <= 1'b1;
    end

    // Interrupt level: set on a match, cleared by a limit read or restarting write
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (ack_read || ack_write)
            irq <= 1'b0;
        else if (match)
            irq <= 1'b1;
    end

endmodule

// File: rtl/lmt_timer.sv
// Limit-match interval counter timer, top level.
// One channel: a count advanced by tick_en, a limit loaded through a word
// register port, and a sticky event with a level interrupt. Assumes full-word
// accesses and that FRAC_W + CNT_W leaves the top data bit free for the flag.
// Read data is registered; read side effects take place at the same edge.
module lmt_timer
    import lmt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int FRAC_W = 9,
    parameter int CNT_W  = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tick_en,
    output logic              irq
);

    localparam int FIELD_HI = FRAC_W + CNT_W - 1;
    localparam int FLAG_POS = DATA_W - 1;

    lmt_cmd_t          cmd;
    lmt_rsel_e         rsel;
    logic [CNT_W-1:0]  count;
    logic [CNT_W-1:0]  limit;
    logic [CNT_W-1:0]  new_limit;
    logic              match;
    logic              reached;
    logic [DATA_W-1:0] count_word;
    logic [DATA_W-1:0] limit_word;
    logic              unused_wdata;

    assign new_limit    = reg_wdata[FIELD_HI:FRAC_W];
    assign unused_wdata = ^{reg_wdata[DATA_W-1:FIELD_HI+1], reg_wdata[FRAC_W-1:0]};

    lmt_addr_dec #(
        .ADDR_W (ADDR_W)
    ) u_dec (
        .addr (reg_addr),
        .wr   (reg_wr),
        .rd   (reg_rd),
        .cmd  (cmd),
        .rsel (rsel)
    );

    lmt_count_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_en),
        .restart    (cmd.load_restart),
        .load_limit (cmd.load_restart || cmd.load_keep),
        .new_limit  (new_limit),
        .count      (count),
        .limit      (limit),
        .match      (match)
    );

    lmt_event_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .match     (match),
        .ack_read  (cmd.read_limit),
        .ack_write (cmd.load_restart),
        .reached   (reached),
        .irq       (irq)
    );

    // Place the count, the flag and the limit at their register bit positions
    always_comb begin
        count_word                  = '0;
        count_word[FIELD_HI:FRAC_W] = count;
        count_word[FLAG_POS]        = reached;
        limit_word                  = '0;
        limit_word[FIELD_HI:FRAC_W] = limit;
    end

    // Register the read data on a read strobe and hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_rd) begin
            case (rsel)
                RSEL_LIMIT: reg_rdata <= limit_word;
                RSEL_COUNT: reg_rdata <= count_word;
                default:    reg_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/lmt_timer_chk.sv
// Port-level protocol checker for lmt_timer, attached by bind.
// Assumes the same word decode as the block: byte address >> 2.
module lmt_timer_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int FRAC_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              tick_en,
    input logic              irq
);

    logic [ADDR_W-3:0] word;
    logic              unused_lane;

    assign word        = reg_addr[ADDR_W-1:2];
    assign unused_lane = ^reg_addr[1:0];

    // R4
    lim_read_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && word == 0) |=> !irq);

    // R5
    lim_write_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && word == 0) |=> !irq);

    // R6
    irq_rise_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tick_en));

    // R2
    cnt_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && word == 1) |=> (reg_rdata[FRAC_W-1:0] == '0));

    // R3
    lim_top_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && word == 0) |=> !reg_rdata[DATA_W-1]);

    // R9
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && word >= 2) |=> (reg_rdata == '0));

    // R13
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

endmodule

bind lmt_timer lmt_timer_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .FRAC_W (FRAC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .tick_en   (tick_en),
    .irq       (irq)
);

// File: tb/lmt_timer_test.sv
`timescale 1ns/1ps
module lmt_timer_test;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int FRAC_W = 9;
    localparam int CNT_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic              reg_rd = 1'b0;
    logic [DATA_W-1:0] reg_rdata;
    logic              tick_en = 1'b0;
    logic              irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    lmt_timer #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .FRAC_W (FRAC_W),
        .CNT_W  (CNT_W)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata),
        .tick_en   (tick_en),
        .irq       (irq)
    );

    function automatic logic [31:0] u(input int n);
        return 32'(n) << FRAC_W;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge
    task automatic wr(input int off, input logic [31:0] d);
        reg_addr  = ADDR_W'(off << 2);
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input int off, output logic [31:0] d);
        reg_addr = ADDR_W'(off << 2);
        reg_rd   = 1'b1;
        @(negedge clk);
        reg_rd   = 1'b0;
        d        = reg_rdata;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic restart(input int lim);
        logic [31:0] d;
        wr(0, u(lim));
        rd(0, d);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1", "irq after reset", {31'b0, irq}, 32'h0);
        rd(1, d); chk("R1", "count after reset", d, 32'h0);
        rd(0, d); chk("R1", "limit after reset", d, 32'h0);
    endtask

    task automatic t_free_count;
        logic [31:0] d;
        ticks(5);
        rd(1, d); chk("R2", "count after 5 ticks", d, u(5));
        ticks(1);
        rd(1, d); chk("R2", "count after 6 ticks", d, u(6));
        repeat (3) @(negedge clk);
        rd(1, d); chk("R2", "count unchanged when idle", d, u(6));
    endtask

    task automatic t_limit_mask;
        logic [31:0] d;
        wr(0, 32'hFFFF_FFFF);
        rd(0, d); chk("R3", "limit keeps only field bits", d, 32'h0001_FE00);
        rd(1, d); chk("R5", "restart write zeroes count", d, 32'h0);
    endtask

    task automatic t_periodic;
        logic [31:0] d;
        restart(10);
        ticks(9);
        chk("R6", "no irq before limit", {31'b0, irq}, 32'h0);
        rd(1, d); chk("R6", "count at L-1", d, u(9));
        ticks(1);
        chk("R6", "irq at match", {31'b0, irq}, 32'h1);
        rd(1, d); chk("R2", "flag in bit 31, count zero", d, 32'h8000_0000);
        chk("R10", "irq held after counter read", {31'b0, irq}, 32'h1);
        repeat (4) @(negedge clk);
        chk("R10", "irq held while idle", {31'b0, irq}, 32'h1);
        rd(0, d); chk("R4", "limit read value", d, u(10));
        chk("R4", "irq cleared by limit read", {31'b0, irq}, 32'h0);
        rd(1, d); chk("R4", "flag cleared by limit read", d, 32'h0);
        ticks(10);
        chk("R6", "second period match", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_write_ack;
        logic [31:0] d;
        wr(0, u(20));
        chk("R5", "restart write clears irq", {31'b0, irq}, 32'h0);
        rd(1, d); chk("R5", "flag kept by restart write", d, 32'h8000_0000);
        rd(0, d); chk("R5", "new limit stored", d, u(20));
    endtask

    task automatic t_keep;
        logic [31:0] d;
        restart(20);
        ticks(7);
        wr(2, u(12));
        rd(1, d); chk("R8", "keep write leaves count", d, u(7));
        rd(0, d); chk("R8", "keep write loads limit", d, u(12));
        ticks(4);
        rd(1, d); chk("R8", "count before new limit", d, u(11));
        chk("R8", "no irq before new limit", {31'b0, irq}, 32'h0);
        ticks(1);
        chk("R8", "match on new limit", {31'b0, irq}, 32'h1);
        rd(0, d);
    endtask

    task automatic t_below;
        logic [31:0] d;
        restart(12);
        ticks(6);
        wr(2, u(3));
        rd(1, d); chk("R8", "count above new limit", d, u(6));
        ticks(249);
        rd(1, d); chk("R8", "count at all ones", d, u(255));
        chk("R8", "no match while above", {31'b0, irq}, 32'h0);
        ticks(1);
        rd(1, d); chk("R8", "wrap without event", d, 32'h0);
        ticks(2);
        chk("R8", "no irq before limit after wrap", {31'b0, irq}, 32'h0);
        ticks(1);
        chk("R8", "match after wrap", {31'b0, irq}, 32'h1);
        rd(1, d); chk("R8", "flag after wrap match", d, 32'h8000_0000);
        rd(0, d);
    endtask

    task automatic t_freerun;
        logic [31:0] d;
        restart(0);
        ticks(255);
        rd(1, d); chk("R7", "free-run at all ones", d, u(255));
        ticks(1);
        rd(1, d); chk("R7", "free-run wraps to zero, no flag", d, 32'h0);
        ticks(300);
        rd(1, d); chk("R7", "free-run after second pass", d, u(44));
        chk("R7", "free-run never interrupts", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        restart(30);
        ticks(5);
        wr(1, 32'hFFFF_FFFF);
        wr(3, 32'hFFFF_FFFF);
        wr(40, 32'h0000_0200);
        rd(1, d); chk("R9", "count unchanged by unmapped writes", d, u(5));
        rd(0, d); chk("R9", "limit unchanged by unmapped writes", d, u(30));
        chk("R9", "irq unchanged by unmapped writes", {31'b0, irq}, 32'h0);
        rd(2, d); chk("R9", "offset 2 reads zero", d, 32'h0);
        rd(3, d); chk("R9", "offset 3 reads zero", d, 32'h0);
        rd(63, d); chk("R9", "offset 63 reads zero", d, 32'h0);
    endtask

    task automatic t_collide;
        logic [31:0] d;
        restart(4);
        ticks(3);
        tick_en  = 1'b1;
        reg_addr = '0;
        reg_rd   = 1'b1;
        @(negedge clk);
        tick_en  = 1'b0;
        reg_rd   = 1'b0;
        chk("R11", "limit read in collision", reg_rdata, u(4));
        chk("R11", "clear wins over match", {31'b0, irq}, 32'h0);
        rd(1, d); chk("R11", "count wrapped, flag clear", d, 32'h0);
        ticks(3);
        chk("R11", "no irq before next match", {31'b0, irq}, 32'h0);
        ticks(1);
        chk("R11", "next match raises irq", {31'b0, irq}, 32'h1);
        rd(0, d);
    endtask

    task automatic t_wr_tick;
        logic [31:0] d;
        restart(40);
        ticks(10);
        tick_en   = 1'b1;
        reg_addr  = '0;
        reg_wdata = u(40);
        reg_wr    = 1'b1;
        @(negedge clk);
        tick_en   = 1'b0;
        reg_wr    = 1'b0;
        rd(1, d); chk("R12", "restart beats tick", d, 32'h0);
        ticks(2);
        rd(1, d); chk("R12", "counting resumes from zero", d, u(2));
    endtask

    task automatic t_hold;
        logic [31:0] d;
        rd(0, d); chk("R13", "read value next cycle", d, u(40));
        ticks(3);
        chk("R13", "rdata holds without read", reg_rdata, u(40));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_free_count();
        t_limit_mask();
        t_periodic();
        t_write_ack();
        t_keep();
        t_below();
        t_freerun();
        t_unmapped();
        t_collide();
        t_wr_tick();
        t_hold();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule